// File: doc/BRIEF.md
# Multiframe Maintenance Channel Transmitter

This block places 4-bit maintenance words into a 20-frame multiframe on a basic-rate line interface. It keeps a frame index that a per-frame strobe advances and a multiframe-start strobe resets. In every fifth frame it presents one bit of the active word on the maintenance output. In terminal mode only the first channel is sent, on the Q positions. In network mode the first channel goes out on the S1x positions, the second on the S2x positions, and a multiframe clock is sent toward the terminals.

Words are written into one-deep pending registers. They are copied to the active registers only at a multiframe start. An optional repetition counter holds each first-channel word for six consecutive multiframes before a queued word may replace it. A one-cycle interrupt marks multiframe starts, either on every multiframe or once per repetition run, as an aid for the controlling software.

Top module: `mfm_tx`

## Requirements
- R1: After reset the channel, the every-multiframe enable and the six-multiframe enable are all off, and `m1_bit`, `m2_bit`, `mf_clk_out` and `mf_irq` are 0.
- R2: A cycle with `frame_tick` and `mf_start` both high sets the frame index to 0. `frame_tick` alone advances it, wrapping after 19. In frames 0, 5, 10 and 15 the outputs carry word bits 3, 2, 1 and 0 in that order. No maintenance bit is output before the first multiframe start after reset.
- R3: In terminal mode (`net_mode`=0) the first-channel word is sent on `m1_bit` and `m2_bit` stays 0, even after a second-channel word is written.
- R4: In network mode (`net_mode`=1) the first-channel word is sent on `m1_bit` and the second-channel word on `m2_bit`, in the same frames.
- R5: With repetition off, a written word becomes active at the next multiframe start. A multiframe already under way completes with the previous word.
- R6: With repetition on, a word that becomes active is sent for six consecutive multiframes. Writes made in that time go to a one-deep pending register, where the latest write wins, and the pending word becomes active at the seventh multiframe start.
- R7: With the every-multiframe enable on, `mf_irq` pulses for one cycle after each multiframe start.
- R8: With only the six-multiframe enable on, `mf_irq` pulses once per held word, at the start of its sixth multiframe.
- R9: Each enable has its own disable command, and a disable wins over an enable given in the same cycle. The six-multiframe disable turns the repetition off, so a pending word becomes active at the next multiframe start.
- R10: With the channel disabled, `m1_bit`, `m2_bit`, `mf_clk_out` and `mf_irq` stay 0. With the channel enabled in network mode, `mf_clk_out` is high during frame 0 of each multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_mode | input | 1 | 1 = network mode, 0 = terminal mode |
| frame_tick | input | 1 | One-cycle strobe per frame |
| mf_start | input | 1 | Marks the tick that begins a multiframe |
| word1_wr | input | 1 | Write strobe, first-channel word |
| word1_in | input | 4 | First-channel word (bit 3 sent first) |
| word2_wr | input | 1 | Write strobe, second-channel word |
| word2_in | input | 4 | Second-channel word (bit 3 sent first) |
| chan_on | input | 1 | Enable channel command |
| chan_off | input | 1 | Disable channel command |
| every_on | input | 1 | Enable per-multiframe interrupt |
| every_off | input | 1 | Disable per-multiframe interrupt |
| six_on | input | 1 | Enable six-multiframe repetition and pacing |
| six_off | input | 1 | Disable six-multiframe repetition and pacing |
| m1_bit | output | 1 | Q / S1x maintenance bit for the current frame |
| m2_bit | output | 1 | S2x maintenance bit for the current frame |
| mf_clk_out | output | 1 | Multiframe clock toward terminals |
| mf_irq | output | 1 | Multiframe interrupt pulse |

## Verification
The assertions assume that `frame_tick` is a one-cycle pulse with at least one idle cycle between ticks, that `mf_start` matters only together with a tick, and that commands and writes are single-cycle pulses. The stimulus drives a tick every fourth cycle, raises `mf_start` on every twentieth tick, and issues commands and writes only in idle cycles between ticks, so no command lands on a multiframe boundary.

// File: rtl/mfm_tx.sv
module mfm_tx #(
  parameter int WORD_W  = 4,
  parameter int SPACING = 5,
  parameter int REPEAT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_mode,
  input  logic              frame_tick,
  input  logic              mf_start,
  input  logic              word1_wr,
  input  logic [WORD_W-1:0] word1_in,
  input  logic              word2_wr,
  input  logic [WORD_W-1:0] word2_in,
  input  logic              chan_on,
  input  logic              chan_off,
  input  logic              every_on,
  input  logic              every_off,
  input  logic              six_on,
  input  logic              six_off,
  output logic              m1_bit,
  output logic              m2_bit,
  output logic              mf_clk_out,
  output logic              mf_irq
);

  localparam int FRAMES = WORD_W * SPACING;
  localparam int FW     = $clog2(FRAMES);
  localparam int CW     = $clog2(REPEAT + 1);

  logic [FW-1:0]     fidx;
  logic              synced, chan_en, every_en, six_en;
  logic [WORD_W-1:0] act1, act2, pend1, pend2;
  logic              pv1, pv2;
  logic [CW-1:0]     rep_cnt;
  logic              on_slot, b1, b2;

  wire mfs      = frame_tick & mf_start;
  wire rep_done = !six_en || (rep_cnt == CW'(REPEAT));
  wire load1    = mfs && pv1 && rep_done;
  wire load2    = mfs && pv2;
  wire live     = synced && chan_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fidx   <= '0;
      synced <= 1'b0;
    end else if (mfs) begin
      fidx   <= '0;
      synced <= 1'b1;
    end else if (frame_tick) begin
      fidx <= (fidx == FW'(FRAMES - 1)) ? '0 : fidx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_en  <= 1'b0;
      every_en <= 1'b0;
      six_en   <= 1'b0;
    end else begin
      chan_en  <= chan_off  ? 1'b0 : (chan_on  | chan_en);
      every_en <= every_off ? 1'b0 : (every_on | every_en);
      six_en   <= six_off   ? 1'b0 : (six_on   | six_en);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rep_cnt <= CW'(REPEAT);
    else if (six_off || !six_en)
      rep_cnt <= CW'(REPEAT);
    else if (load1)
      rep_cnt <= CW'(1);
    else if (mfs && rep_cnt < CW'(REPEAT))
      rep_cnt <= rep_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act1  <= '0;
      pend1 <= '0;
      pv1   <= 1'b0;
      act2  <= '0;
      pend2 <= '0;
      pv2   <= 1'b0;
    end else begin
      if (load1) begin
        act1 <= pend1;
        pv1  <= 1'b0;
      end
      if (word1_wr) begin
        pend1 <= word1_in;
        pv1   <= 1'b1;
      end
      if (load2) begin
        act2 <= pend2;
        pv2  <= 1'b0;
      end
      if (word2_wr) begin
        pend2 <= word2_in;
        pv2   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mf_irq <= 1'b0;
    else
      mf_irq <= mfs && chan_en &&
                (every_en || (six_en && rep_cnt == CW'(REPEAT - 1)));
  end

  always_comb begin
    on_slot = 1'b0;
    b1      = 1'b0;
    b2      = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (fidx == FW'(i * SPACING)) begin
        on_slot = 1'b1;
        b1      = act1[WORD_W-1-i];
        b2      = act2[WORD_W-1-i];
      end
    end
  end

  assign m1_bit     = live && on_slot && b1;
  assign m2_bit     = live && on_slot && net_mode && b2;
  assign mf_clk_out = live && net_mode && (fidx == '0);

  p_irq_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mf_irq |-> $past(frame_tick && mf_start && chan_en));

  p_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!chan_en) && !chan_en) |-> !mf_irq);

  p_term_no_s2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !net_mode |-> !m2_bit);

  p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mfs && six_en && rep_cnt < CW'(REPEAT)) |=> $stable(act1));

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_cnt != '0) && (rep_cnt <= CW'(REPEAT)));

  p_load_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act1) |-> $past(frame_tick && mf_start));

  p_pulse_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mf_irq |=> !mf_irq);

endmodule

// File: tb/mfm_tx_tb.sv
`timescale 1ns/1ps
module mfm_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic net_mode = 1'b0, frame_tick = 1'b0, mf_start = 1'b0;
  logic word1_wr = 1'b0, word2_wr = 1'b0;
  logic [3:0] word1_in = '0, word2_in = '0;
  logic chan_on = 1'b0, chan_off = 1'b0, every_on = 1'b0, every_off = 1'b0;
  logic six_on = 1'b0, six_off = 1'b0;
  logic m1_bit, m2_bit, mf_clk_out, mf_irq;

  int tests = 0, fails = 0;
  logic [3:0] got1, got2;
  int irq_n;
  logic clk0, clk1;

  always #10 clk = ~clk;

  mfm_tx u_dut (
    .clk(clk), .rst_n(rst_n), .net_mode(net_mode), .frame_tick(frame_tick),
    .mf_start(mf_start), .word1_wr(word1_wr), .word1_in(word1_in),
    .word2_wr(word2_wr), .word2_in(word2_in), .chan_on(chan_on),
    .chan_off(chan_off), .every_on(every_on), .every_off(every_off),
    .six_on(six_on), .six_off(six_off), .m1_bit(m1_bit), .m2_bit(m2_bit),
    .mf_clk_out(mf_clk_out), .mf_irq(mf_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic wr1(input logic [3:0] d);
    @(negedge clk); word1_in = d; word1_wr = 1'b1;
    @(negedge clk); word1_wr = 1'b0;
  endtask

  task automatic wr2(input logic [3:0] d);
    @(negedge clk); word2_in = d; word2_wr = 1'b1;
    @(negedge clk); word2_wr = 1'b0;
  endtask

  // one frame: tick for one cycle, sample right after the edge, then idle
  task automatic frame(input logic start, output logic s1, output logic s2,
                       output logic irq, output logic mc);
    @(negedge clk); frame_tick = 1'b1; mf_start = start;
    @(negedge clk); frame_tick = 1'b0; mf_start = 1'b0;
    s1 = m1_bit; s2 = m2_bit; irq = mf_irq; mc = mf_clk_out;
    @(negedge clk);
    if (mf_irq) irq = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_mf(input int wr_at, input logic [3:0] wd);
    logic s1, s2, irq, mc;
    got1 = '0; got2 = '0; irq_n = 0; clk0 = 1'b0; clk1 = 1'b0;
    for (int f = 0; f < 20; f++) begin
      frame(f == 0, s1, s2, irq, mc);
      if (f % 5 == 0) begin
        got1[3 - f/5] = s1;
        got2[3 - f/5] = s2;
      end
      if (irq) irq_n++;
      if (f == 0) clk0 = mc;
      if (f == 1) clk1 = mc;
      if (f == wr_at) wr1(wd);
    end
  endtask

  task automatic t_reset();
    logic s1, s2, irq, mc;
    chk("R1 m1_bit", m1_bit, 0);
    chk("R1 m2_bit", m2_bit, 0);
    chk("R1 mf_clk_out", mf_clk_out, 0);
    chk("R1 mf_irq", mf_irq, 0);
    pulse(chan_on);
    net_mode = 1'b1;
    wr1(4'hF);
    wr2(4'hF);
    frame(1'b0, s1, s2, irq, mc);
    chk("R2 no bit before sync m1", s1, 0);
    chk("R2 no bit before sync m2", s2, 0);
    chk("R2 no clock before sync", mc, 0);
    net_mode = 1'b0;
  endtask

  task automatic t_terminal();
    wr1(4'hA);
    wr2(4'h6);
    run_mf(-1, 4'h0);
    chk("R2 R3 terminal word order", got1, 4'hA);
    chk("R3 terminal s2 silent", got2, 0);
    chk("R1 no irq with enables off", irq_n, 0);
    chk("R10 no clock in terminal mode", clk0, 0);
  endtask

  task automatic t_network();
    net_mode = 1'b1;
    wr1(4'h5);
    wr2(4'hC);
    run_mf(-1, 4'h0);
    chk("R4 network s1 word", got1, 4'h5);
    chk("R4 network s2 word", got2, 4'hC);
    chk("R10 clock in frame 0", clk0, 1);
    chk("R10 clock low in frame 1", clk1, 0);
    net_mode = 1'b0;
  endtask

  task automatic t_no_repeat();
    run_mf(7, 4'h9);
    chk("R5 old word completes", got1, 4'h5);
    run_mf(-1, 4'h0);
    chk("R5 new word next start", got1, 4'h9);
  endtask

  task automatic t_repeat();
    pulse(six_on);
    wr1(4'h1);
    run_mf(-1, 4'h0);
    chk("R6 first run word", got1, 4'h1);
    chk("R8 no irq on load", irq_n, 0);
    wr1(4'h2);
    wr1(4'h4);
    for (int m = 2; m <= 6; m++) begin
      run_mf(-1, 4'h0);
      chk("R6 word held", got1, 4'h1);
      chk("R8 irq only in sixth", irq_n, (m == 6) ? 1 : 0);
    end
    run_mf(-1, 4'h0);
    chk("R6 latest pending after six", got1, 4'h4);
    chk("R8 no irq on new word", irq_n, 0);
  endtask

  task automatic t_every();
    pulse(every_on);
    run_mf(-1, 4'h0);
    chk("R7 irq each multiframe a", irq_n, 1);
    run_mf(-1, 4'h0);
    chk("R7 irq each multiframe b", irq_n, 1);
  endtask

  task automatic t_disables();
    pulse(every_off);
    wr1(4'h7);
    run_mf(-1, 4'h0);
    chk("R9 still held while six on", got1, 4'h4);
    pulse(six_off);
    run_mf(-1, 4'h0);
    chk("R9 six off releases pending", got1, 4'h7);
    chk("R9 no irq after both off", irq_n, 0);
    @(negedge clk); every_on = 1'b1; every_off = 1'b1;
    @(negedge clk); every_on = 1'b0; every_off = 1'b0;
    run_mf(-1, 4'h0);
    chk("R9 disable wins", irq_n, 0);
  endtask

  task automatic t_chan();
    net_mode = 1'b1;
    pulse(every_on);
    pulse(chan_off);
    wr2(4'h3);
    run_mf(-1, 4'h0);
    chk("R10 off m1 silent", got1, 0);
    chk("R10 off m2 silent", got2, 0);
    chk("R10 off no clock", clk0, 0);
    chk("R10 off no irq", irq_n, 0);
    pulse(chan_on);
    run_mf(-1, 4'h0);
    chk("R10 on clock back", clk0, 1);
    chk("R10 on irq back", irq_n, 1);
    chk("R4 s2 word after re-enable", got2, 4'h3);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_terminal();
    t_network();
    t_no_repeat();
    t_repeat();
    t_every();
    t_disables();
    t_chan();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule